// File: doc/BRIEF.md
# UART Receiver with Per-Entry Error Status

This block is the receive half of a serial port. It watches an asynchronous line through a short synchronizer and a 16x oversampling tick supplied from outside. It assembles frames of 5 to 8 data bits with an optional parity bit and one or two stop bits, then stores each byte in a 16-entry FIFO. Every entry carries its own error status. Software sees the oldest entry's data and status on `rd_data` and `rd_err` without consuming it. Pulsing `pop` moves on to the next entry.

The FIFO reports occupancy as a 4-bit count plus a separate full flag. The block raises a level interrupt when occupancy reaches a programmable threshold. A sticky timeout interrupt is set after four idle character times following the last received frame, whether or not the FIFO still holds data. Dropping `rx_en` flushes the FIFO, the pending overrun and the timeout, and returns the receiver to idle.

The receiver is a state machine with these states:
- `ST_IDLE`: waits for a low line.
- `ST_START`: validates the start bit.
- `ST_DATA`: collects data bits.
- `ST_PARITY`: takes the parity bit.
- `ST_STOP`: checks the stop bits and pushes the entry.
- `ST_WAIT_HIGH`: entered after a low final stop sample; waits for the line to return high.

Its transitions are:
- IDLE→START on a low line at a tick.
- START→IDLE when the mid sample is high, and START→DATA when it is low.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP.
- STOP→IDLE or STOP→WAIT_HIGH after the final stop sample.
- WAIT_HIGH→IDLE once the line is high.
- Any state→IDLE while `rx_en` is low.

Top module: `uart_rx_core`

## Requirements
- R1: Frames are one low start bit, then N data bits LSB first, then optional parity, then stop bits. N is `data_len`+5, so 0 gives 5 bits and 3 gives 8. Unused upper bits of `rd_data` read 0. `two_stop`=1 adds a second stop bit.
- R2: `par_mode` selects the parity: 0 none, 1 even, 2 odd, 3 bit always 1, 4 bit always 0; values 5 to 7 act as none. A mismatch sets status bit 1 of that entry.
- R3: A low sample in any stop bit sets status bit 2 (frame error). After a low final stop sample the receiver waits for a high line before it accepts a new start.
- R4: A frame whose every sample is low, stop bits included, is stored as data 0 with status bits 3 (break) and 2 both set.
- R5: `rd_data`/`rd_err` show the oldest entry without consuming it. Status bits are [0] overrun, [1] parity, [2] frame, [3] break. Only `pop` advances the FIFO. A `pop` while the FIFO is empty has no effect.
- R6: A frame that completes while the FIFO holds 16 entries, with no pop in that cycle, is discarded. Status bit 0 is then set on the next entry popped, and on that entry only.
- R7: `rx_cnt` gives the occupancy modulo 16. `rx_full` is high exactly when 16 entries are held, and `rx_cnt` then reads 0.
- R8: `trig_irq` is high while the occupancy is at least `trig_lvl` and `trig_lvl` is nonzero.
- R9: Each completed frame arms a timer of 4 character times, where a character time is the configured frame length in bits times 16 ticks. When the timer expires, `tout_irq` sets regardless of FIFO occupancy. It stays set until `tout_ack`. A new start bit before expiry cancels the timer.
- R10: While `rx_en` is low, the FIFO is emptied, the pending overrun and the timeout are cleared, and the receiver returns to idle.
- R11: After reset, count, full, `trig_irq` and `tout_irq` are all 0.
- R12: A start is validated by a line sample at oversample count 8, where the detecting tick counts as 1. A low pulse that is high at that sample is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low flushes and idles the block |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| data_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | 1 selects two stop bits |
| par_mode | input | 3 | Parity selection, see R2 |
| trig_lvl | input | 5 | Occupancy threshold for `trig_irq`, 0 disables |
| pop | input | 1 | Consume the oldest entry |
| tout_ack | input | 1 | Clears `tout_irq` |
| rd_data | output | 8 | Oldest entry data |
| rd_err | output | 4 | Oldest entry status |
| rx_cnt | output | 4 | Occupancy modulo 16 |
| rx_full | output | 1 | FIFO holds 16 entries |
| trig_irq | output | 1 | Threshold interrupt |
| tout_irq | output | 1 | Receive-timeout interrupt |

## Verification
- **Sampling errors.** A misaligned oversample counter or a wrong bit index shows up as corrupted data or a false parity or frame flag on the very first received byte, one character time after its start bit.
- **FIFO state errors.** A bad read or write pointer shows as out-of-order data on the next pop. A pending overrun that never clears shows as status bit 0 on entries after the first.
- **Timeout errors.** A timer that is not cancelled, or is loaded with the wrong limit, shows as `tout_irq` firing early or late, within the four-character window after a frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OS_RATE = 16;
    localparam int OS_MID  = 8;
    localparam int MAX_FRAME_BITS = 12;

    localparam logic [2:0] PAR_NONE = 3'd0;
    localparam logic [2:0] PAR_EVEN = 3'd1;
    localparam logic [2:0] PAR_ODD  = 3'd2;
    localparam logic [2:0] PAR_ONE  = 3'd3;
    localparam logic [2:0] PAR_ZERO = 3'd4;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } line_err_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] data_len,
    input  logic       two_stop,
    input  logic [2:0] par_mode,
    output logic       start_det,
    output logic       push_v,
    output logic [7:0] push_data,
    output line_err_t  push_err,
    output logic [3:0] frame_bits
);

    logic rxd_s;

    generate
        if (SYNC_LEN > 0) begin : g_sync
            logic [SYNC_LEN-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_LEN-2:0], rxd};
            end
            assign rxd_s = sync_q[SYNC_LEN-1];
        end else begin : g_nosync
            assign rxd_s = rxd;
        end
    endgenerate

    rx_state_e  state_q, state_d;
    logic [3:0] os_cnt;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic       par_bit;
    logic       all_low;
    logic       stop_idx;
    logic       stop_bad;

    logic [3:0] nbits;
    logic       par_en;
    logic       mid;
    logic       last_bit;
    logic       final_stop;
    logic       par_err;
    logic       xr;

    assign nbits      = {2'b00, data_len} + 4'd5;
    assign par_en     = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD) ||
                        (par_mode == PAR_ONE)  || (par_mode == PAR_ZERO);
    assign frame_bits = 4'd2 + nbits + {3'b000, par_en} + {3'b000, two_stop};
    assign mid        = os_tick && (os_cnt == 4'(OS_MID));
    assign last_bit   = ({1'b0, bit_idx} == (nbits - 4'd1));
    assign final_stop = !two_stop || stop_idx;
    assign start_det  = rx_en && (state_q == ST_IDLE) && os_tick && !rxd_s;
    assign xr         = (^shreg) ^ par_bit;

    always_comb begin
        unique case (par_mode)
            PAR_EVEN: par_err = xr;
            PAR_ODD:  par_err = !xr;
            PAR_ONE:  par_err = !par_bit;
            PAR_ZERO: par_err = par_bit;
            default:  par_err = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (!rx_en) state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (os_tick && !rxd_s) state_d = ST_START;
            ST_START:     if (mid) state_d = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:      if (mid && last_bit) state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:    if (mid) state_d = ST_STOP;
            ST_STOP:      if (mid && final_stop) state_d = rxd_s ? ST_IDLE : ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (rxd_s) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt    <= 4'd1;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            all_low   <= 1'b0;
            stop_idx  <= 1'b0;
            stop_bad  <= 1'b0;
            push_v    <= 1'b0;
            push_data <= '0;
            push_err  <= '0;
        end else if (!rx_en) begin
            os_cnt    <= 4'd1;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            all_low   <= 1'b0;
            stop_idx  <= 1'b0;
            stop_bad  <= 1'b0;
            push_v    <= 1'b0;
        end else begin
            push_v <= 1'b0;
            if (state_q == ST_IDLE) os_cnt <= 4'd1;
            else if (os_tick)       os_cnt <= os_cnt + 4'd1;
            unique case (state_q)
                ST_START: if (mid) begin
                    bit_idx  <= '0;
                    shreg    <= '0;
                    par_bit  <= 1'b0;
                    all_low  <= 1'b1;
                    stop_idx <= 1'b0;
                    stop_bad <= 1'b0;
                end
                ST_DATA: if (mid) begin
                    shreg[bit_idx] <= rxd_s;
                    all_low        <= all_low & ~rxd_s;
                    bit_idx        <= bit_idx + 3'd1;
                end
                ST_PARITY: if (mid) begin
                    par_bit <= rxd_s;
                    all_low <= all_low & ~rxd_s;
                end
                ST_STOP: if (mid) begin
                    if (!final_stop) begin
                        stop_idx <= 1'b1;
                        stop_bad <= stop_bad | ~rxd_s;
                        all_low  <= all_low & ~rxd_s;
                    end else begin
                        push_v       <= 1'b1;
                        push_data    <= shreg;
                        push_err.brk <= all_low & ~rxd_s;
                        push_err.frm <= stop_bad | ~rxd_s;
                        push_err.par <= par_err;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_v,
    input  logic [7:0]    push_data,
    input  line_err_t     push_err,
    input  logic          pop,
    output logic [7:0]    rd_data,
    output logic [3:0]    rd_err,
    output logic [AW-1:0] cnt,
    output logic          full,
    output logic [AW:0]   occ
);

    logic [7:0]    data_q [DEPTH];
    line_err_t     err_q  [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          ovr_pend;

    logic pop_ok;
    logic room;
    logic do_push;
    logic ovf;
    logic empty;

    assign empty   = (occ == '0);
    assign pop_ok  = pop && !empty;
    assign room    = (occ != (AW+1)'(DEPTH)) || pop_ok;
    assign do_push = push_v && room;
    assign ovf     = push_v && !room;

    always_ff @(posedge clk) begin
        if (do_push) begin
            data_q[wr_ptr] <= push_data;
            err_q[wr_ptr]  <= push_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            ovr_pend <= 1'b0;
        end else if (clr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            occ <= occ + (AW+1)'(do_push) - (AW+1)'(pop_ok);
            if (ovf)         ovr_pend <= 1'b1;
            else if (pop_ok) ovr_pend <= 1'b0;
        end
    end

    assign rd_data = empty ? 8'h00 : data_q[rd_ptr];
    assign rd_err  = empty ? 4'h0  : {err_q[rd_ptr], ovr_pend};
    assign cnt     = occ[AW-1:0];
    assign full    = occ[AW];

endmodule

// File: rtl/uart_rx_tout.sv
module uart_rx_tout
    import uart_rx_pkg::*;
#(
    parameter int TOUT_CHARS = 4,
    localparam int TW = $clog2(TOUT_CHARS * MAX_FRAME_BITS * OS_RATE + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       push_v,
    input  logic       start_det,
    input  logic [3:0] frame_bits,
    input  logic       tout_ack,
    output logic       tout_irq
);

    logic [TW-1:0] tcnt;
    logic [TW-1:0] limit;
    logic          armed;

    assign limit = TW'(frame_bits) * TW'(TOUT_CHARS * OS_RATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            armed    <= 1'b0;
            tout_irq <= 1'b0;
        end else if (!rx_en) begin
            tcnt     <= '0;
            armed    <= 1'b0;
            tout_irq <= 1'b0;
        end else begin
            if (tout_ack) tout_irq <= 1'b0;
            if (start_det) begin
                armed <= 1'b0;
            end else if (push_v) begin
                armed <= 1'b1;
                tcnt  <= '0;
            end else if (armed && os_tick) begin
                if (tcnt == limit - TW'(1)) begin
                    armed    <= 1'b0;
                    tout_irq <= 1'b1;
                end else begin
                    tcnt <= tcnt + TW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int SYNC_LEN   = 2,
    parameter int TOUT_CHARS = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic [1:0]    data_len,
    input  logic          two_stop,
    input  logic [2:0]    par_mode,
    input  logic [CW-1:0] trig_lvl,
    input  logic          pop,
    input  logic          tout_ack,
    output logic [7:0]    rd_data,
    output logic [3:0]    rd_err,
    output logic [AW-1:0] rx_cnt,
    output logic          rx_full,
    output logic          trig_irq,
    output logic          tout_irq
);

    logic       start_det;
    logic       frm_push;
    logic [7:0] frm_data;
    line_err_t  frm_err;
    logic [3:0] frame_bits;
    logic [AW:0] occ;

    uart_rx_frame #(.SYNC_LEN(SYNC_LEN)) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .data_len   (data_len),
        .two_stop   (two_stop),
        .par_mode   (par_mode),
        .start_det  (start_det),
        .push_v     (frm_push),
        .push_data  (frm_data),
        .push_err   (frm_err),
        .frame_bits (frame_bits)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!rx_en),
        .push_v    (frm_push),
        .push_data (frm_data),
        .push_err  (frm_err),
        .pop       (pop),
        .rd_data   (rd_data),
        .rd_err    (rd_err),
        .cnt       (rx_cnt),
        .full      (rx_full),
        .occ       (occ)
    );

    uart_rx_tout #(.TOUT_CHARS(TOUT_CHARS)) i_tout (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .os_tick    (os_tick),
        .push_v     (frm_push),
        .start_det  (start_det),
        .frame_bits (frame_bits),
        .tout_ack   (tout_ack),
        .tout_irq   (tout_irq)
    );

    assign trig_irq = (trig_lvl != '0) && (occ >= trig_lvl);

endmodule

// File: rtl/uart_rx_sva.sv
module uart_rx_sva #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          pop,
    input logic          push_v,
    input logic [7:0]    rd_data,
    input logic [3:0]    rd_err,
    input logic [AW-1:0] rx_cnt,
    input logic          rx_full,
    input logic          tout_ack,
    input logic          tout_irq
);

    logic [AW:0] occ_w;
    assign occ_w = {rx_full, rx_cnt};

    a_r7_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && pop && (occ_w != '0) && !push_v |=> occ_w == $past(occ_w) - 1'b1);

    a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && pop && (occ_w == '0) && !push_v |=> occ_w == '0);

    a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && !pop && (occ_w != '0) |=> $stable(rd_data) && $stable(rd_err[3:1]));

    a_r4_break_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_w != '0) && rd_err[3] |-> rd_err[2]);

    a_r10_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (occ_w == '0) && !tout_irq);

    a_r9_tout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && tout_irq && !tout_ack |=> tout_irq);

    a_r6_overrun_marks_head: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && push_v && rx_full && !pop |=> rx_full && rd_err[0]);

endmodule

bind uart_rx_core uart_rx_sva #(.DEPTH(DEPTH)) i_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .pop      (pop),
    .push_v   (frm_push),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .rx_cnt   (rx_cnt),
    .rx_full  (rx_full),
    .tout_ack (tout_ack),
    .tout_irq (tout_irq)
);

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] data_len = 2'd3;
    logic       two_stop = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic [4:0] trig_lvl = 5'd0;
    logic       mon_pop = 1'b0;
    logic       man_pop = 1'b0;
    logic       pop;
    logic       tout_ack = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] rd_err;
    logic [3:0] rx_cnt;
    logic       rx_full;
    logic       trig_irq;
    logic       tout_irq;

    assign pop = mon_pop | man_pop;

    always #2 clk = ~clk;

    uart_rx_core i_uart_rx_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .data_len (data_len),
        .two_stop (two_stop),
        .par_mode (par_mode),
        .trig_lvl (trig_lvl),
        .pop      (pop),
        .tout_ack (tout_ack),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .rx_cnt   (rx_cnt),
        .rx_full  (rx_full),
        .trig_irq (trig_irq),
        .tout_irq (tout_irq)
    );

    typedef struct {
        logic [7:0] d;
        logic [3:0] e;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   auto_pop = 1'b1;
    bit   done = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_pop) begin
                mon_pop = 1'b0;
            end else if (auto_pop && (rx_full || rx_cnt != 0)) begin
                if (q.size() == 0) begin
                    check("R5", "unexpected entry data", {24'd0, rd_data}, 32'hFFFF_FFFF);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    check(it.tag, "data", {24'd0, rd_data}, {24'd0, it.d});
                    check(it.tag, "status", {28'd0, rd_err}, {28'd0, it.e});
                end
                mon_pop = 1'b1;
            end
        end
    end

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par,
                              input bit bad_stop, input bit enq, input string tag);
        int   n;
        bit   pe;
        logic [7:0] dm;
        logic p;
        exp_t it;
        n  = int'(data_len) + 5;
        pe = (par_mode >= 3'd1) && (par_mode <= 3'd4);
        dm = d & 8'((1 << n) - 1);
        case (par_mode)
            3'd1:    p = ^dm;
            3'd2:    p = ~^dm;
            3'd3:    p = 1'b1;
            default: p = 1'b0;
        endcase
        if (bad_par) p = ~p;
        if (enq) begin
            it.d = dm;
            it.e = {1'b0, bad_stop, bad_par && pe, 1'b0};
            it.tag = tag;
            q.push_back(it);
        end
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(dm[i]);
        if (pe) drive_bit(p);
        if (two_stop) drive_bit(1'b1);
        drive_bit(!bad_stop);
        if (bad_stop) drive_bit(1'b1);
    endtask

    task automatic pulse_pop();
        man_pop = 1'b1;
        @(negedge clk);
        man_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack_tout();
        tout_ack = 1'b1;
        @(negedge clk);
        tout_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        exp_t br;
        repeat (5) @(negedge clk);
        // R11 reset state
        check("R11", "rx_cnt", {28'd0, rx_cnt}, 0);
        check("R11", "rx_full", {31'd0, rx_full}, 0);
        check("R11", "trig_irq", {31'd0, trig_irq}, 0);
        check("R11", "tout_irq", {31'd0, tout_irq}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        repeat (64) @(negedge clk);

        // R1 8-bit frames, LSB first
        send_frame(8'hA5, 0, 0, 1, "R1");
        send_frame(8'h3C, 0, 0, 1, "R1");
        send_frame(8'h00, 0, 0, 1, "R1");
        // R1 5-bit frames, upper bits zero
        data_len = 2'd0;
        send_frame(8'h1B, 0, 0, 1, "R1");
        send_frame(8'hFF, 0, 0, 1, "R1");
        data_len = 2'd2;
        send_frame(8'h6D, 0, 0, 1, "R1");
        data_len = 2'd3;

        // R2 each parity mode, good then bad
        for (int m = 1; m <= 4; m++) begin
            par_mode = 3'(m);
            send_frame(8'h5A, 0, 0, 1, "R2");
            send_frame(8'h5B, 1, 0, 1, "R2");
        end
        data_len = 2'd0;
        par_mode = 3'd2;
        send_frame(8'h15, 0, 0, 1, "R2");
        send_frame(8'h1F, 1, 0, 1, "R2");
        data_len = 2'd3;
        par_mode = 3'd0;

        // R1 two stop bits, R3 bad second stop
        two_stop = 1'b1;
        send_frame(8'h81, 0, 0, 1, "R1");
        send_frame(8'h7E, 0, 1, 1, "R3");
        two_stop = 1'b0;
        // R3 bad single stop
        send_frame(8'h55, 0, 1, 1, "R3");

        // R4 break held past the frame; R3 waits for high line
        br.d = 8'h00; br.e = 4'b1100; br.tag = "R4";
        q.push_back(br);
        rxd = 1'b0;
        repeat (12 * 64) @(negedge clk);
        rxd = 1'b1;
        repeat (128) @(negedge clk);
        check("R4", "queue drained", q.size(), 0);
        check("R3", "no extra entry after long low", {28'd0, rx_cnt}, 0);

        // R12 short low pulse rejected
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (700) @(negedge clk);
        check("R12", "glitch ignored count", {27'd0, rx_full, rx_cnt}, 0);

        // R5 manual head access
        auto_pop = 0;
        repeat (4) @(negedge clk);
        pulse_pop();
        check("R5", "pop on empty count", {27'd0, rx_full, rx_cnt}, 0);
        send_frame(8'h42, 0, 0, 0, "R5");
        repeat (8) @(negedge clk);
        check("R5", "head data", {24'd0, rd_data}, 32'h42);
        check("R5", "head status", {28'd0, rd_err}, 0);
        repeat (10) @(negedge clk);
        check("R5", "head still present", {28'd0, rx_cnt}, 1);
        check("R5", "head data stable", {24'd0, rd_data}, 32'h42);
        pulse_pop();
        check("R5", "after pop count", {27'd0, rx_full, rx_cnt}, 0);

        // R8 trigger level
        trig_lvl = 5'd3;
        send_frame(8'h01, 0, 0, 0, "R8");
        send_frame(8'h02, 0, 0, 0, "R8");
        repeat (8) @(negedge clk);
        check("R8", "below level", {31'd0, trig_irq}, 0);
        send_frame(8'h03, 0, 0, 0, "R8");
        repeat (8) @(negedge clk);
        check("R8", "at level", {31'd0, trig_irq}, 1);
        check("R7", "count 3", {27'd0, rx_full, rx_cnt}, 3);
        // R10 disable flushes
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "count cleared", {27'd0, rx_full, rx_cnt}, 0);
        check("R10", "trig cleared", {31'd0, trig_irq}, 0);
        rx_en = 1'b1;
        trig_lvl = 5'd0;
        repeat (64) @(negedge clk);

        // R6 / R7 overrun with 17 frames
        for (int i = 0; i < 17; i++) send_frame(8'(8'h10 + i), 0, 0, 0, "R6");
        repeat (8) @(negedge clk);
        check("R7", "full flag", {31'd0, rx_full}, 1);
        check("R7", "count when full", {28'd0, rx_cnt}, 0);
        check("R6", "oldest data", {24'd0, rd_data}, 32'h10);
        check("R6", "oldest overrun", {28'd0, rd_err}, 32'h1);
        pulse_pop();
        check("R7", "count after one pop", {27'd0, rx_full, rx_cnt}, 15);
        for (int i = 1; i < 16; i++) begin
            check("R6", "data order", {24'd0, rd_data}, 32'(8'h10 + i));
            check("R6", "later overrun clear", {28'd0, rd_err}, 0);
            pulse_pop();
        end
        check("R6", "seventeenth dropped", {27'd0, rx_full, rx_cnt}, 0);

        // R9 timeout
        auto_pop = 1;
        ack_tout();
        send_frame(8'h77, 0, 0, 1, "R9");
        repeat (2400) @(negedge clk);
        check("R9", "not yet expired", {31'd0, tout_irq}, 0);
        repeat (250) @(negedge clk);
        check("R9", "expired", {31'd0, tout_irq}, 1);
        check("R9", "fifo empty while timeout", {27'd0, rx_full, rx_cnt}, 0);
        ack_tout();
        check("R9", "ack clears", {31'd0, tout_irq}, 0);
        send_frame(8'h78, 0, 0, 1, "R9");
        repeat (2000) @(negedge clk);
        send_frame(8'h79, 0, 0, 1, "R9");
        check("R9", "start cancels timer", {31'd0, tout_irq}, 0);
        repeat (2650) @(negedge clk);
        check("R9", "second expiry", {31'd0, tout_irq}, 1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "timeout cleared", {31'd0, tout_irq}, 0);
        rx_en = 1'b1;
        repeat (16) @(negedge clk);

        check("R5", "all expected entries seen", q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule